// File: doc/BRIEF.md
# Multilevel Priority Interrupt Controller

This block arbitrates interrupt requests for a processing unit across 32 priority levels. Levels 0 to 3 are internal and have a single source each. Levels 4 to 31 are external, and each one groups up to four sources. Every source has its own request latch, arm bit and enable bit, and its level is fixed by its position. Software reaches each source through a small command port. Through that port it can arm, disarm, enable, disable or trigger one source at a time.

The controller never interrupts on its own. It weighs requests only when the processor raises a test-point strobe. At that point the best eligible request must beat the level of the task now running, and the global mask must be clear. When a grant is made, the controller reports the level and the source index within the group. It also records the new current level.

When a task ends, a deactivate strobe acknowledges its request. Control then falls through to the next waiting request at the same or a lower priority. If no request is waiting, the controller reports idle. One external level can be set aside as a fast level, and grants on it also pulse a register-bank switch output.

Top module: `irq_prio_ctl`

## Requirements
- R1: After reset the controller is idle, `cur_lvl` reads 31, `grant` and `bank_sw` are 0, and every source is disarmed, disabled and has no latched request.
- R2: A disarmed source ignores rising edges on its input. Disarming a source (`cmd_op`=2) also clears any request it has latched. Arming (`cmd_op`=1) takes effect from the next cycle.
- R3: An armed source latches a request on a rising edge of its input, where source s of level l is `irq_in[4*l+s]`. A level held high after acknowledgement does not latch again.
- R4: The trigger command (`cmd_op`=5) latches a request on an armed source, just as an input edge does.
- R5: An armed but disabled source keeps its latched request but cannot be granted. Once it is enabled (`cmd_op`=3), it can be granted. Disable is `cmd_op`=4.
- R6: A grant happens only in the cycle after `test_pt` is high with `mask_in` low. The requesting level must be strictly higher in priority (a lower number) than `cur_lvl`, unless the controller is idle. `grant` then pulses for one cycle together with `grant_lvl` and `grant_src`, and `cur_lvl` takes the granted level in that same cycle.
- R7: A lower level number wins over a higher one. Within a level, the lower source index wins.
- R8: A deactivate strobe acknowledges (clears) the request of the running source. `cur_lvl` then moves to the best eligible request whose level is equal to or lower in priority than the running level. If there is none, the controller becomes idle. No grant pulse is produced by this move.
- R9: `bank_sw` pulses together with `grant` exactly when the granted level equals the fast level (default 4).
- R10: For internal levels 0 to 3, only source 0 exists. Inputs and commands for source indices 1 to 3 of those levels have no effect.
- R11: A deactivate strobe takes precedence over a test-point strobe in the same cycle, so no grant occurs in that cycle. A deactivate strobe while idle has no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| irq_in | input | 128 | Raw request inputs, bit 4*level+source |
| mask_in | input | 1 | Global interrupt mask indicator, 1 blocks grants |
| test_pt | input | 1 | Interrupt test-point strobe |
| deact | input | 1 | Deactivate current task strobe |
| cmd_op | input | 3 | Command: 0 none, 1 arm, 2 disarm, 3 enable, 4 disable, 5 trigger |
| cmd_lvl | input | 5 | Level addressed by the command |
| cmd_src | input | 2 | Source within level addressed by the command |
| grant | output | 1 | One-cycle grant pulse |
| grant_lvl | output | 5 | Level of the last grant |
| grant_src | output | 2 | Source index of the last grant |
| cur_lvl | output | 5 | Level of the running task, 31 when idle |
| idle | output | 1 | No task running |
| bank_sw | output | 1 | Register-bank switch pulse for fast-level grants |

## Verification
If a request latch is corrupted, the fault shows at the next test point. A grant then appears that should not, or an expected one goes missing, one cycle after the strobe. A wrong current-level register is harder to see. It only shows when a later request is wrongly accepted or refused for preemption, or when a deactivate falls through to the wrong level. For that reason, the nested cases check `cur_lvl` after every deactivate, not only after grants. Errors in arm or enable state stay hidden until an edge or trigger arrives and a test point follows, so each control bit is probed by a stimulus that is followed at once by a test point.

// File: rtl/irqc_pkg.sv
package irqc_pkg;
  typedef enum logic [2:0] {
    OP_NONE    = 3'd0,
    OP_ARM     = 3'd1,
    OP_DISARM  = 3'd2,
    OP_ENABLE  = 3'd3,
    OP_DISABLE = 3'd4,
    OP_TRIGGER = 3'd5
  } irq_op_e;
endpackage

// File: rtl/irqc_src_bank.sv
module irqc_src_bank
  import irqc_pkg::*;
#(
  parameter int N_LVL = 32,
  parameter int N_SRC = 4,
  parameter int N_INT = 4,
  localparam int LVL_W = $clog2(N_LVL),
  localparam int SRC_W = $clog2(N_SRC),
  localparam int NS    = N_LVL * N_SRC,
  localparam int IDX_W = $clog2(NS)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [NS-1:0]    irq_in,
  input  irq_op_e          op,
  input  logic [LVL_W-1:0] cmd_lvl,
  input  logic [SRC_W-1:0] cmd_src,
  input  logic             ack_vld,
  input  logic [IDX_W-1:0] ack_idx,
  output logic [NS-1:0]    eligible
);

  for (genvar i = 0; i < NS; i++) begin : g_src
    localparam int LV = i / N_SRC;
    localparam int SI = i % N_SRC;
    if (LV < N_INT && SI != 0) begin : g_stub
      logic unused_stub;
      assign unused_stub = irq_in[i];
      assign eligible[i] = 1'b0;
    end else begin : g_real
      logic arm_q, en_q, pend_q, prev_q;
      logic arm_d, en_d, pend_d;
      logic sel, set, clr;

      always_comb begin
        sel   = (int'(cmd_lvl) == LV) && (int'(cmd_src) == SI);
        arm_d = arm_q;
        en_d  = en_q;
        if (sel) begin
          if (op == OP_ARM)     arm_d = 1'b1;
          if (op == OP_DISARM)  arm_d = 1'b0;
          if (op == OP_ENABLE)  en_d  = 1'b1;
          if (op == OP_DISABLE) en_d  = 1'b0;
        end
        set    = arm_q && ((irq_in[i] && !prev_q) || (sel && op == OP_TRIGGER));
        clr    = (sel && op == OP_DISARM) || (ack_vld && int'(ack_idx) == i);
        pend_d = (pend_q || set) && !clr;
      end

      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
          arm_q  <= 1'b0;
          en_q   <= 1'b0;
          pend_q <= 1'b0;
          prev_q <= 1'b0;
        end else begin
          arm_q  <= arm_d;
          en_q   <= en_d;
          pend_q <= pend_d;
          prev_q <= irq_in[i];
        end
      end

      assign eligible[i] = pend_q && en_q;
    end
  end

endmodule

// File: rtl/irqc_pick.sv
module irqc_pick #(
  parameter int W = 128,
  localparam int IW = $clog2(W)
) (
  input  logic [W-1:0]  vec,
  output logic          found,
  output logic [IW-1:0] idx
);
  always_comb begin
    idx = '0;
    for (int k = W - 1; k >= 0; k--) begin
      if (vec[k]) idx = IW'(k);
    end
  end
  assign found = |vec;
endmodule

// File: rtl/irqc_level_ctl.sv
module irqc_level_ctl #(
  parameter int LVL_W    = 5,
  parameter int SRC_W    = 2,
  parameter int FAST_LVL = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             test_pt,
  input  logic             mask_in,
  input  logic             deact,
  input  logic             best_found,
  input  logic [LVL_W-1:0] best_lvl,
  input  logic [SRC_W-1:0] best_src,
  input  logic             fall_found,
  input  logic [LVL_W-1:0] fall_lvl,
  input  logic [SRC_W-1:0] fall_src,
  output logic             ack_vld,
  output logic [LVL_W+SRC_W-1:0] ack_idx,
  output logic [LVL_W-1:0] cur_lvl,
  output logic             idle,
  output logic             grant,
  output logic [LVL_W-1:0] grant_lvl,
  output logic [SRC_W-1:0] grant_src,
  output logic             bank_sw
);
  logic [LVL_W-1:0] cur_q, cur_d, gl_q, gl_d;
  logic [SRC_W-1:0] src_q, src_d, gs_q, gs_d;
  logic             idle_q, idle_d, gnt_q, gnt_d, bank_q, bank_d;
  logic             take;

  always_comb begin
    cur_d  = cur_q;
    src_d  = src_q;
    idle_d = idle_q;
    gl_d   = gl_q;
    gs_d   = gs_q;
    gnt_d  = 1'b0;
    bank_d = 1'b0;
    take   = test_pt && !mask_in && best_found && (idle_q || best_lvl < cur_q);
    if (deact) begin
      if (!idle_q) begin
        if (fall_found) begin
          cur_d = fall_lvl;
          src_d = fall_src;
        end else begin
          idle_d = 1'b1;
          cur_d  = '1;
          src_d  = '0;
        end
      end
    end else if (take) begin
      cur_d  = best_lvl;
      src_d  = best_src;
      idle_d = 1'b0;
      gnt_d  = 1'b1;
      gl_d   = best_lvl;
      gs_d   = best_src;
      bank_d = (best_lvl == LVL_W'(FAST_LVL));
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cur_q  <= '1;
      src_q  <= '0;
      idle_q <= 1'b1;
      gl_q   <= '0;
      gs_q   <= '0;
      gnt_q  <= 1'b0;
      bank_q <= 1'b0;
    end else begin
      cur_q  <= cur_d;
      src_q  <= src_d;
      idle_q <= idle_d;
      gl_q   <= gl_d;
      gs_q   <= gs_d;
      gnt_q  <= gnt_d;
      bank_q <= bank_d;
    end
  end

  assign ack_vld   = deact && !idle_q;
  assign ack_idx   = {cur_q, src_q};
  assign cur_lvl   = cur_q;
  assign idle      = idle_q;
  assign grant     = gnt_q;
  assign grant_lvl = gl_q;
  assign grant_src = gs_q;
  assign bank_sw   = bank_q;
endmodule

// File: rtl/irq_prio_ctl.sv
module irq_prio_ctl
  import irqc_pkg::*;
#(
  parameter int N_LVL    = 32,
  parameter int N_INT    = 4,
  parameter int N_SRC    = 4,
  parameter int FAST_LVL = 4,
  localparam int LVL_W = $clog2(N_LVL),
  localparam int SRC_W = $clog2(N_SRC),
  localparam int NS    = N_LVL * N_SRC,
  localparam int IDX_W = $clog2(NS)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [NS-1:0]    irq_in,
  input  logic             mask_in,
  input  logic             test_pt,
  input  logic             deact,
  input  logic [2:0]       cmd_op,
  input  logic [LVL_W-1:0] cmd_lvl,
  input  logic [SRC_W-1:0] cmd_src,
  output logic             grant,
  output logic [LVL_W-1:0] grant_lvl,
  output logic [SRC_W-1:0] grant_src,
  output logic [LVL_W-1:0] cur_lvl,
  output logic             idle,
  output logic             bank_sw
);
  logic [NS-1:0]    elig, fall_vec;
  logic             ack_vld, best_found, fall_found;
  logic [IDX_W-1:0] ack_idx, best_idx, fall_idx;

  irqc_src_bank #(.N_LVL(N_LVL), .N_SRC(N_SRC), .N_INT(N_INT)) u_bank (
    .clk(clk), .rst_n(rst_n), .irq_in(irq_in), .op(irq_op_e'(cmd_op)),
    .cmd_lvl(cmd_lvl), .cmd_src(cmd_src), .ack_vld(ack_vld),
    .ack_idx(ack_idx), .eligible(elig)
  );

  for (genvar i = 0; i < NS; i++) begin : g_fall
    assign fall_vec[i] = elig[i] && ((i / N_SRC) >= int'(cur_lvl))
                         && !(ack_vld && int'(ack_idx) == i);
  end

  irqc_pick #(.W(NS)) u_best (.vec(elig), .found(best_found), .idx(best_idx));
  irqc_pick #(.W(NS)) u_fall (.vec(fall_vec), .found(fall_found), .idx(fall_idx));

  irqc_level_ctl #(.LVL_W(LVL_W), .SRC_W(SRC_W), .FAST_LVL(FAST_LVL)) u_ctl (
    .clk(clk), .rst_n(rst_n), .test_pt(test_pt), .mask_in(mask_in),
    .deact(deact), .best_found(best_found),
    .best_lvl(best_idx[IDX_W-1:SRC_W]), .best_src(best_idx[SRC_W-1:0]),
    .fall_found(fall_found),
    .fall_lvl(fall_idx[IDX_W-1:SRC_W]), .fall_src(fall_idx[SRC_W-1:0]),
    .ack_vld(ack_vld), .ack_idx(ack_idx), .cur_lvl(cur_lvl), .idle(idle),
    .grant(grant), .grant_lvl(grant_lvl), .grant_src(grant_src),
    .bank_sw(bank_sw)
  );
endmodule

// File: rtl/irqc_checker.sv
module irqc_checker #(
  parameter int LVL_W    = 5,
  parameter int FAST_LVL = 4
) (
  input logic             clk,
  input logic             rst_n,
  input logic             test_pt,
  input logic             mask_in,
  input logic             deact,
  input logic             grant,
  input logic [LVL_W-1:0] grant_lvl,
  input logic [LVL_W-1:0] cur_lvl,
  input logic             idle,
  input logic             bank_sw
);
  p_grant_at_test_r6: assert property (@(posedge clk) disable iff (!rst_n)
    grant |-> ($past(test_pt) && !$past(mask_in) && !$past(deact)));

  p_grant_higher_r6: assert property (@(posedge clk) disable iff (!rst_n)
    grant |-> ($past(idle) || grant_lvl < $past(cur_lvl)));

  p_grant_sets_cur_r6: assert property (@(posedge clk) disable iff (!rst_n)
    grant |-> (cur_lvl == grant_lvl && !idle));

  p_bank_only_fast_r9: assert property (@(posedge clk) disable iff (!rst_n)
    bank_sw |-> (grant && grant_lvl == LVL_W'(FAST_LVL)));

  p_bank_on_fast_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (grant && grant_lvl == LVL_W'(FAST_LVL)) |-> bank_sw);

  p_idle_level_r1: assert property (@(posedge clk) disable iff (!rst_n)
    idle |-> (cur_lvl == '1));

  p_deact_falls_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (deact && !idle) |=> (idle || cur_lvl >= $past(cur_lvl)));

  p_deact_idle_r11: assert property (@(posedge clk) disable iff (!rst_n)
    (deact && idle) |=> (idle && !grant));
endmodule

bind irq_prio_ctl irqc_checker #(.LVL_W(LVL_W), .FAST_LVL(FAST_LVL)) u_chk (
  .clk(clk), .rst_n(rst_n), .test_pt(test_pt), .mask_in(mask_in),
  .deact(deact), .grant(grant), .grant_lvl(grant_lvl), .cur_lvl(cur_lvl),
  .idle(idle), .bank_sw(bank_sw)
);

// File: tb/tb_irq_prio_ctl.sv
module tb_irq_prio_ctl;
  localparam int CLK_PERIOD = 10;

  logic         clk = 1'b0;
  logic         rst_n;
  logic [127:0] irq_in;
  logic         mask_in, test_pt, deact;
  logic [2:0]   cmd_op;
  logic [4:0]   cmd_lvl;
  logic [1:0]   cmd_src;
  logic         grant, idle, bank_sw;
  logic [4:0]   grant_lvl, cur_lvl;
  logic [1:0]   grant_src;
  int n_chk = 0;
  int n_err = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  irq_prio_ctl dut (
    .clk(clk), .rst_n(rst_n), .irq_in(irq_in), .mask_in(mask_in),
    .test_pt(test_pt), .deact(deact), .cmd_op(cmd_op), .cmd_lvl(cmd_lvl),
    .cmd_src(cmd_src), .grant(grant), .grant_lvl(grant_lvl),
    .grant_src(grant_src), .cur_lvl(cur_lvl), .idle(idle), .bank_sw(bank_sw)
  );

  task automatic chk(input string tag, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_err++;
      $display("FAIL %s: actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic cmd(input int op, input int l, input int s);
    @(negedge clk);
    cmd_op = 3'(op); cmd_lvl = 5'(l); cmd_src = 2'(s);
    @(negedge clk);
    cmd_op = 3'd0;
  endtask

  task automatic arm_en(input int l, input int s);
    cmd(1, l, s);
    cmd(3, l, s);
  endtask

  task automatic edge_on(input int l, input int s);
    @(negedge clk);
    irq_in[4*l+s] = 1'b1;
    @(negedge clk);
    irq_in[4*l+s] = 1'b0;
  endtask

  task automatic tp(input string tag, input bit exp_g, input int l, input int s);
    @(negedge clk);
    test_pt = 1'b1;
    @(negedge clk);
    test_pt = 1'b0;
    chk({tag, " grant"}, int'(grant), int'(exp_g));
    if (exp_g) begin
      chk({tag, " grant_lvl"}, int'(grant_lvl), l);
      chk({tag, " grant_src"}, int'(grant_src), s);
      chk({tag, " cur_lvl (R6)"}, int'(cur_lvl), l);
      chk({tag, " bank_sw (R9)"}, int'(bank_sw), int'(l == 4));
    end
  endtask

  task automatic dx(input string tag, input int exp_lvl, input bit exp_idle);
    @(negedge clk);
    deact = 1'b1;
    @(negedge clk);
    deact = 1'b0;
    chk({tag, " cur_lvl"}, int'(cur_lvl), exp_lvl);
    chk({tag, " idle"}, int'(idle), int'(exp_idle));
    chk({tag, " no grant pulse"}, int'(grant), 0);
  endtask

  task automatic t_reset;
    chk("R1 idle", int'(idle), 1);
    chk("R1 cur_lvl", int'(cur_lvl), 31);
    chk("R1 grant", int'(grant), 0);
    chk("R1 bank_sw", int'(bank_sw), 0);
    edge_on(10, 1);
    tp("R1 nothing armed", 1'b0, 0, 0);
  endtask

  task automatic t_arm_edge;
    edge_on(10, 1);
    arm_en(10, 1);
    tp("R2 disarmed edge ignored", 1'b0, 0, 0);
    edge_on(10, 1);
    tp("R3 edge grant", 1'b1, 10, 1);
    @(negedge clk);
    chk("R6 one-cycle pulse", int'(grant), 0);
    @(negedge clk);
    irq_in[41] = 1'b1;
    dx("R8 to idle", 31, 1'b1);
    tp("R3 held level no relatch", 1'b0, 0, 0);
    @(negedge clk);
    irq_in[41] = 1'b0;
    edge_on(10, 1);
    cmd(2, 10, 1);
    arm_en(10, 1);
    tp("R2 disarm clears latch", 1'b0, 0, 0);
  endtask

  task automatic t_trigger;
    arm_en(20, 3);
    cmd(5, 20, 3);
    tp("R4 trigger", 1'b1, 20, 3);
    dx("R4 done", 31, 1'b1);
  endtask

  task automatic t_enable;
    cmd(1, 12, 0);
    edge_on(12, 0);
    tp("R5 disabled held", 1'b0, 0, 0);
    cmd(3, 12, 0);
    tp("R5 enabled grant", 1'b1, 12, 0);
    dx("R5 done", 31, 1'b1);
  endtask

  task automatic t_mask_nest;
    arm_en(7, 2); arm_en(7, 0); arm_en(9, 0);
    edge_on(7, 2);
    mask_in = 1'b1;
    tp("R6 masked", 1'b0, 0, 0);
    mask_in = 1'b0;
    tp("R6 unmasked", 1'b1, 7, 2);
    edge_on(9, 0);
    tp("R6 lower refused", 1'b0, 0, 0);
    edge_on(7, 0);
    tp("R6 equal refused", 1'b0, 0, 0);
    dx("R8 same level", 7, 1'b0);
    dx("R8 next lower", 9, 1'b0);
    dx("R8 empty", 31, 1'b1);
  endtask

  task automatic t_priority;
    arm_en(15, 2); arm_en(15, 1); arm_en(25, 0); arm_en(2, 0);
    @(negedge clk);
    irq_in[62] = 1'b1; irq_in[61] = 1'b1; irq_in[100] = 1'b1;
    @(negedge clk);
    irq_in[62] = 1'b0; irq_in[61] = 1'b0; irq_in[100] = 1'b0;
    tp("R7 lowest level and source", 1'b1, 15, 1);
    edge_on(2, 0);
    tp("R7 preempt by internal", 1'b1, 2, 0);
    dx("R8 resume preempted", 15, 1'b0);
    dx("R8 next source same level", 15, 1'b0);
    dx("R8 lower level", 25, 1'b0);
    dx("R8 idle", 31, 1'b1);
  endtask

  task automatic t_bank;
    arm_en(4, 3);
    edge_on(4, 3);
    tp("R9 fast level", 1'b1, 4, 3);
    dx("R9 done", 31, 1'b1);
  endtask

  task automatic t_internal;
    arm_en(1, 2);
    edge_on(1, 2);
    cmd(5, 1, 2);
    tp("R10 stub source", 1'b0, 0, 0);
    arm_en(1, 0);
    edge_on(1, 0);
    tp("R10 real internal source", 1'b1, 1, 0);
    dx("R10 done", 31, 1'b1);
  endtask

  task automatic t_conflict;
    arm_en(30, 0); arm_en(5, 0);
    edge_on(30, 0);
    @(negedge clk);
    test_pt = 1'b1; deact = 1'b1;
    @(negedge clk);
    test_pt = 1'b0; deact = 1'b0;
    chk("R11 idle deact blocks grant", int'(grant), 0);
    chk("R11 stays idle", int'(idle), 1);
    tp("R11 later grant", 1'b1, 30, 0);
    edge_on(5, 0);
    @(negedge clk);
    test_pt = 1'b1; deact = 1'b1;
    @(negedge clk);
    test_pt = 1'b0; deact = 1'b0;
    chk("R11 deact wins grant", int'(grant), 0);
    chk("R11 deact wins cur_lvl", int'(cur_lvl), 31);
    tp("R11 higher after", 1'b1, 5, 0);
    dx("R11 done", 31, 1'b1);
  endtask

  initial begin
    #(CLK_PERIOD * 100000);
    n_chk++; n_err++;
    $display("FAIL watchdog: actual=timeout expected=finish");
    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end

  initial begin
    rst_n = 1'b0; irq_in = '0; mask_in = 1'b0; test_pt = 1'b0; deact = 1'b0;
    cmd_op = '0; cmd_lvl = '0; cmd_src = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset;
    t_arm_edge;
    t_trigger;
    t_enable;
    t_mask_nest;
    t_priority;
    t_bank;
    t_internal;
    t_conflict;
    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end
endmodule